// File: doc/BRIEF.md
# Remote-Management Command Decoder

This block sits behind a serial management slave that has already captured the write half of a process-call transaction. That write half is a command code, a write length and up to ten payload bytes. The block checks the payload and turns it into a processor-state access. It either answers at once with a status-only or stored-data response, or it issues one request to a register-store model over a simple valid/acknowledge port and answers when that request completes. Every response starts with a status byte. Any data bytes follow it, least significant first.

Register writes take two commands. The first loads a 32-bit register address into a per-core address table, for one core or for all cores at once. The second sends the data bytes, and the block attaches the address stored for the selected core. A read-back command returns the status and data of the most recently completed request. This lets a master recover a result whose response it missed. Only one request may be outstanding. Any command that arrives while a request is pending is answered with the busy code. A timeout flag from outside ends a pending request without data.

Top module: `rmi_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, `req_valid` and `rsp_valid` are 0. The saved read-back result is status 00h with all-zero data.
- R2: Code 73h with payload byte 1 = 86h and write length 7 is a register read. Byte 0 is the count, byte 2 bits [4:1] select the core, and bytes 3..6 hold the address, least significant first. The block raises `req_valid` with `req_kind`=0, `req_nbytes`=count and `req_addr`=address. After `req_ack`, it responds with length count+1: status 00h, then the low count bytes of `req_rdata`.
- R3: Code 73h with byte 1 = 91h and write length 8 is a CPUID read. Byte 0 must be 08h, bytes 3..6 hold the function number and byte 7 is the half selector (0 or 1). The request has `req_kind`=1, `req_nbytes`=8, `req_addr`=function and `req_wdata` bit 0 = selector. After `req_ack`, the response is 9 bytes: status 00h and all eight bytes of `req_rdata`.
- R4: Code 71h with byte 0 = 81h and write length 6 is a load-address command. Byte 1 bits [4:1] select the core and bit 0 means all cores. Bytes 2..5 hold the address. The address is stored for that core, or for every core when broadcast, and a one-byte 00h response follows. No request is issued.
- R5: Code 71h with byte 0 = 87h and write length 3..10 is a register write. It sends length−2 data bytes, taken from byte 2 upward, to the address stored for the core in byte 1 bits [4:1]. The request has `req_kind`=2, and unsent data bytes read as zero. After `req_ack`, a one-byte 00h response follows.
- R6: Code 72h with write length 1 and byte 0 = count (1..8) responds with length count+1. The response holds the saved status, then the low count bytes of the saved data from the last completed request. Write completions save zero data.
- R7: An unrecognised command code, or code 73h or 71h with an unrecognised subcommand byte, gives status 40h.
- R8: For the three read commands, a count of 0 or above 32 gives 41h. A count of 1..31 whose sum with the write length exceeds 32 gives 42h.
- R9: Status 45h is given in these cases: the write length does not match the command; a read count (or a read-back count) is above 8; a CPUID count is not 8; or a CPUID selector is above 1.
- R10: A selected core whose `core_ok` bit is 0 gives 44h. A broadcast gives 44h if any `core_ok` bit is 0. A rejected load stores nothing.
- R11: A command that arrives while `req_valid` is 1 gives 20h and leaves the pending request unchanged. This holds even in the cycle the request completes. In that cycle the completion is saved for read-back but gets no response of its own. Checks are applied in this order: 20h, 40h, the length 45h, 41h, 42h, the other 45h cases, then 44h.
- R12: If `req_tmo` is 1 while a request is pending and `req_ack` is 0, the request is dropped. A one-byte 11h response follows, and the saved result becomes status 11h with zero data.
- R13: Error, load and read-back responses appear one cycle after the command edge. A request appears one cycle after its command edge and produces no immediate response. Its response appears one cycle after the completing edge. No other response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: a captured command is present |
| cmd_code | input | 8 | Command code byte |
| cmd_wlen | input | 8 | Write length (payload byte count) |
| cmd_bytes | input | 80 | Payload, byte i at bits [8i+7:8i] |
| core_ok | input | 16 | Per-core availability (enabled and not spinning) |
| req_valid | output | 1 | Request pending to the register store |
| req_kind | output | 2 | 0 read, 1 CPUID, 2 write |
| req_core | output | 4 | Target core |
| req_all | output | 1 | Write targets all cores |
| req_addr | output | 32 | Register address or CPUID function |
| req_nbytes | output | 4 | Bytes to read or write (1..8) |
| req_wdata | output | 64 | Write data, or CPUID selector in bit 0 |
| req_ack | input | 1 | Register store completes the pending request |
| req_rdata | input | 64 | Read data returned with `req_ack` |
| req_tmo | input | 1 | Timeout flag for the pending request |
| rsp_valid | output | 1 | One-cycle strobe: response present |
| rsp_len | output | 6 | Response byte count including status |
| rsp_bytes | output | 72 | Response, status in bits [7:0], data bytes above |

## Verification
Error, load and read-back results are due one cycle after the edge that takes the command. A request shows on the request port at that same time, and its response is due one cycle after the edge that sees `req_ack` or `req_tmo`. The driver changes inputs only at falling edges and pushes each expected response into a queue before it applies the stimulus that causes it. A monitor compares every `rsp_valid` seen at the next falling edge against the head of that queue. A response that arrives early, late or unasked therefore shows up as a mismatch, an unexpected response or a leftover queue entry. Request-port fields and the unchanged pending request are checked at the falling edge right after the command.

// File: rtl/rmi_dec_pkg.sv
// Package: command/subcommand codes, status codes, operation and request
// kinds shared by the decoder, its sub-blocks and its checker.
package rmi_dec_pkg;
    localparam int PAYLOAD_BYTES = 10;
    localparam int DATA_BYTES    = 8;

    localparam logic [7:0] CC_WRITE  = 8'h71;
    localparam logic [7:0] CC_RDSTAT = 8'h72;
    localparam logic [7:0] CC_READ   = 8'h73;
    localparam logic [7:0] SC_LOAD   = 8'h81;
    localparam logic [7:0] SC_WRREG  = 8'h87;
    localparam logic [7:0] SC_RDREG  = 8'h86;
    localparam logic [7:0] SC_CPUID  = 8'h91;

    localparam logic [7:0] ST_OK     = 8'h00;
    localparam logic [7:0] ST_TMO    = 8'h11;
    localparam logic [7:0] ST_BUSY   = 8'h20;
    localparam logic [7:0] ST_BADFMT = 8'h40;
    localparam logic [7:0] ST_BADRL  = 8'h41;
    localparam logic [7:0] ST_LONG   = 8'h42;
    localparam logic [7:0] ST_CORE   = 8'h44;
    localparam logic [7:0] ST_UNSUP  = 8'h45;

    typedef enum logic [2:0] {
        OP_NONE, OP_RDREG, OP_CPUID, OP_RDSTAT, OP_LOAD, OP_WRREG
    } op_e;

    localparam logic [1:0] RK_READ  = 2'd0;
    localparam logic [1:0] RK_CPUID = 2'd1;
    localparam logic [1:0] RK_WRITE = 2'd2;

    // Keep the low n bytes of d, zero the rest.
    function automatic logic [63:0] keep_bytes(input logic [63:0] d, input logic [3:0] n);
        logic [63:0] r;
        for (int i = 0; i < DATA_BYTES; i++)
            r[8*i +: 8] = (4'(i) < n) ? d[8*i +: 8] : 8'h00;
        return r;
    endfunction
endpackage

// File: rtl/rmi_cmd_check.sv
// Combinational command validator: classifies the captured payload into an
// operation, extracts its fields and picks the status by a fixed priority
// (busy, format, length match, read length, total length, unsupported, core).
// Assumes NCORES <= 16 and payload byte i at cmd_bytes[8i +: 8].
module rmi_cmd_check
    import rmi_dec_pkg::*;
#(
    parameter int NCORES = 16
) (
    input  logic                         busy,
    input  logic [7:0]                   cmd_code,
    input  logic [7:0]                   cmd_wlen,
    input  logic [8*PAYLOAD_BYTES-1:0]   cmd_bytes,
    input  logic [NCORES-1:0]            core_ok,
    output logic [7:0]                   status,
    output op_e                          op,
    output logic [3:0]                   core,
    output logic                         bcast,
    output logic [7:0]                   cnt,
    output logic [31:0]                  field32,
    output logic                         sel,
    output logic [3:0]                   wcnt,
    output logic [63:0]                  wdata
);
    logic [7:0] b [PAYLOAD_BYTES];
    logic [7:0] core_byte;
    logic [15:0] ok16;
    logic [8:0] len_sum;
    logic is_rd, len_ok, core_bad;

    // Split the flat payload into bytes.
    always_comb begin
        for (int i = 0; i < PAYLOAD_BYTES; i++) b[i] = cmd_bytes[8*i +: 8];
    end

    // Classify the command code and subcommand byte.
    always_comb begin
        op = OP_NONE;
        case (cmd_code)
            CC_READ:   if (b[1] == SC_RDREG) op = OP_RDREG;
                       else if (b[1] == SC_CPUID) op = OP_CPUID;
            CC_RDSTAT: op = OP_RDSTAT;
            CC_WRITE:  if (b[0] == SC_LOAD) op = OP_LOAD;
                       else if (b[0] == SC_WRREG) op = OP_WRREG;
            default:   op = OP_NONE;
        endcase
    end

    // Extract fields from their positions.
    always_comb begin
        core_byte = (op == OP_RDREG || op == OP_CPUID) ? b[2] : b[1];
        core      = core_byte[4:1];
        bcast     = (op == OP_LOAD || op == OP_WRREG) && core_byte[0];
        cnt       = b[0];
        field32   = (op == OP_LOAD) ? {b[5], b[4], b[3], b[2]} : {b[6], b[5], b[4], b[3]};
        sel       = b[7][0];
        wcnt      = 4'(cmd_wlen - 8'd2);
        for (int i = 0; i < DATA_BYTES; i++)
            wdata[8*i +: 8] = (4'(i) < wcnt) ? b[2+i] : 8'h00;
    end

    // Length and core availability conditions.
    always_comb begin
        ok16 = '0;
        ok16[NCORES-1:0] = core_ok;
        is_rd   = (op == OP_RDREG) || (op == OP_CPUID) || (op == OP_RDSTAT);
        len_sum = {1'b0, cnt} + {1'b0, cmd_wlen};
        case (op)
            OP_RDREG:  len_ok = (cmd_wlen == 8'd7);
            OP_CPUID:  len_ok = (cmd_wlen == 8'd8);
            OP_RDSTAT: len_ok = (cmd_wlen == 8'd1);
            OP_LOAD:   len_ok = (cmd_wlen == 8'd6);
            OP_WRREG:  len_ok = (cmd_wlen >= 8'd3) && (cmd_wlen <= 8'd10);
            default:   len_ok = 1'b0;
        endcase
        core_bad = bcast ? !(&core_ok) : !ok16[core];
    end

    // Status by priority.
    always_comb begin
        status = ST_OK;
        if (busy)                                          status = ST_BUSY;
        else if (op == OP_NONE)                            status = ST_BADFMT;
        else if (!len_ok)                                  status = ST_UNSUP;
        else if (is_rd && (cnt == 8'd0 || cnt > 8'd32))    status = ST_BADRL;
        else if (is_rd && cnt <= 8'd31 && len_sum > 9'd32) status = ST_LONG;
        else if (is_rd && (cnt > 8'd8 ||
                 (op == OP_CPUID && (cnt != 8'd8 || b[7] > 8'd1))))
                                                           status = ST_UNSUP;
        else if (op != OP_RDSTAT && core_bad)              status = ST_CORE;
    end
endmodule

// File: rtl/rmi_addr_table.sv
// Per-core stored register address table with broadcast load and a
// combinational read port. Assumes wcore < NCORES when a single load is done.
module rmi_addr_table #(
    parameter int NCORES = 16,
    parameter int AW     = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          all,
    input  logic [3:0]    wcore,
    input  logic [AW-1:0] waddr,
    input  logic [3:0]    rcore,
    output logic [AW-1:0] raddr
);
    logic [AW-1:0] tbl [NCORES];

    for (genvar c = 0; c < NCORES; c++) begin : g_entry
        // One entry: loaded on a matching or broadcast write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   tbl[c] <= '0;
            else if (we && (all || wcore == 4'(c)))       tbl[c] <= waddr;
        end
    end

    // Read mux over the entries.
    always_comb begin
        raddr = '0;
        for (int c = 0; c < NCORES; c++)
            if (rcore == 4'(c)) raddr = tbl[c];
    end
endmodule

// File: rtl/rmi_req_ctrl.sv
// Request handshake, saved read-back result and response formatter.
// Holds one request until ack or timeout; a command in the completion cycle
// owns the response (it sees busy), the completion is only saved.
module rmi_req_ctrl
    import rmi_dec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [7:0]  status,
    input  op_e         op,
    input  logic [3:0]  core,
    input  logic        bcast,
    input  logic [7:0]  cnt,
    input  logic [31:0] field32,
    input  logic        sel,
    input  logic [3:0]  wcnt,
    input  logic [63:0] wdata,
    input  logic [31:0] tbl_addr,
    input  logic        req_ack,
    input  logic [63:0] req_rdata,
    input  logic        req_tmo,
    output logic        req_valid,
    output logic [1:0]  req_kind,
    output logic [3:0]  req_core,
    output logic        req_all,
    output logic [31:0] req_addr,
    output logic [3:0]  req_nbytes,
    output logic [63:0] req_wdata,
    output logic        rsp_valid,
    output logic [5:0]  rsp_len,
    output logic [71:0] rsp_bytes
);
    logic [3:0]  ret_n;
    logic [7:0]  last_st;
    logic [63:0] last_data;

    // Request, saved result and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid  <= 1'b0;
            req_kind   <= RK_READ;
            req_core   <= '0;
            req_all    <= 1'b0;
            req_addr   <= '0;
            req_nbytes <= '0;
            req_wdata  <= '0;
            ret_n      <= '0;
            last_st    <= ST_OK;
            last_data  <= '0;
            rsp_valid  <= 1'b0;
            rsp_len    <= '0;
            rsp_bytes  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (req_valid && (req_ack || req_tmo)) begin
                req_valid <= 1'b0;
                rsp_valid <= 1'b1;
                if (req_ack) begin
                    last_st   <= ST_OK;
                    last_data <= (req_kind == RK_WRITE) ? 64'h0 : req_rdata;
                    rsp_len   <= {2'b00, ret_n} + 6'd1;
                    rsp_bytes <= {keep_bytes(req_rdata, ret_n), ST_OK};
                end else begin
                    last_st   <= ST_TMO;
                    last_data <= '0;
                    rsp_len   <= 6'd1;
                    rsp_bytes <= {64'h0, ST_TMO};
                end
            end
            if (cmd_valid) begin
                if (status != ST_OK) begin
                    rsp_valid <= 1'b1;
                    rsp_len   <= 6'd1;
                    rsp_bytes <= {64'h0, status};
                end else if (op == OP_LOAD) begin
                    rsp_valid <= 1'b1;
                    rsp_len   <= 6'd1;
                    rsp_bytes <= {64'h0, ST_OK};
                end else if (op == OP_RDSTAT) begin
                    rsp_valid <= 1'b1;
                    rsp_len   <= cnt[5:0] + 6'd1;
                    rsp_bytes <= {keep_bytes(last_data, cnt[3:0]), last_st};
                end else begin
                    req_valid <= 1'b1;
                    req_core  <= core;
                    req_all   <= bcast;
                    case (op)
                        OP_CPUID: begin
                            req_kind   <= RK_CPUID;
                            req_addr   <= field32;
                            req_nbytes <= 4'd8;
                            req_wdata  <= {63'h0, sel};
                            ret_n      <= 4'd8;
                        end
                        OP_WRREG: begin
                            req_kind   <= RK_WRITE;
                            req_addr   <= tbl_addr;
                            req_nbytes <= wcnt;
                            req_wdata  <= wdata;
                            ret_n      <= 4'd0;
                        end
                        default: begin
                            req_kind   <= RK_READ;
                            req_addr   <= field32;
                            req_nbytes <= cnt[3:0];
                            req_wdata  <= '0;
                            ret_n      <= cnt[3:0];
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/rmi_cmd_decoder.sv
// Top: validates captured remote-management commands, keeps the per-core
// load-address table and drives one register-store request at a time.
// Assumes cmd_valid is a one-cycle strobe per captured command.
module rmi_cmd_decoder
    import rmi_dec_pkg::*;
#(
    parameter int NCORES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [7:0]                 cmd_code,
    input  logic [7:0]                 cmd_wlen,
    input  logic [8*PAYLOAD_BYTES-1:0] cmd_bytes,
    input  logic [NCORES-1:0]          core_ok,
    output logic                       req_valid,
    output logic [1:0]                 req_kind,
    output logic [3:0]                 req_core,
    output logic                       req_all,
    output logic [31:0]                req_addr,
    output logic [3:0]                 req_nbytes,
    output logic [63:0]                req_wdata,
    input  logic                       req_ack,
    input  logic [63:0]                req_rdata,
    input  logic                       req_tmo,
    output logic                       rsp_valid,
    output logic [5:0]                 rsp_len,
    output logic [8*(DATA_BYTES+1)-1:0] rsp_bytes
);
    logic [7:0]  status;
    op_e         op;
    logic [3:0]  core;
    logic        bcast;
    logic [7:0]  cnt;
    logic [31:0] field32;
    logic        sel;
    logic [3:0]  wcnt;
    logic [63:0] wdata;
    logic [31:0] tbl_addr;
    logic        tbl_we;

    rmi_cmd_check #(.NCORES(NCORES)) u_check (
        .busy(req_valid), .cmd_code(cmd_code), .cmd_wlen(cmd_wlen),
        .cmd_bytes(cmd_bytes), .core_ok(core_ok), .status(status), .op(op),
        .core(core), .bcast(bcast), .cnt(cnt), .field32(field32), .sel(sel),
        .wcnt(wcnt), .wdata(wdata)
    );

    // Table is loaded only by an accepted load-address command.
    assign tbl_we = cmd_valid && (status == ST_OK) && (op == OP_LOAD);

    rmi_addr_table #(.NCORES(NCORES), .AW(32)) u_table (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .all(bcast), .wcore(core),
        .waddr(field32), .rcore(core), .raddr(tbl_addr)
    );

    rmi_req_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .status(status),
        .op(op), .core(core), .bcast(bcast), .cnt(cnt), .field32(field32),
        .sel(sel), .wcnt(wcnt), .wdata(wdata), .tbl_addr(tbl_addr),
        .req_ack(req_ack), .req_rdata(req_rdata), .req_tmo(req_tmo),
        .req_valid(req_valid), .req_kind(req_kind), .req_core(req_core),
        .req_all(req_all), .req_addr(req_addr), .req_nbytes(req_nbytes),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_len(rsp_len),
        .rsp_bytes(rsp_bytes)
    );
endmodule

// File: rtl/rmi_cmd_decoder_chk.sv
// Checker bound to the decoder: handshake, busy, timeout and response shape.
module rmi_cmd_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        req_valid,
    input logic [1:0]  req_kind,
    input logic [3:0]  req_core,
    input logic [31:0] req_addr,
    input logic [3:0]  req_nbytes,
    input logic        req_ack,
    input logic        req_tmo,
    input logic        rsp_valid,
    input logic [5:0]  rsp_len,
    input logic [71:0] rsp_bytes
);
    // R11
    busy_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && req_valid |=> rsp_valid && rsp_bytes[7:0] == 8'h20 && rsp_len == 6'd1);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ack && !req_tmo |=> req_valid && $stable(req_addr)
            && $stable(req_core) && $stable(req_kind) && $stable(req_nbytes));
    // R13
    ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ack && !cmd_valid |=> rsp_valid && rsp_bytes[7:0] == 8'h00);
    // R12
    tmo_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_tmo && !req_ack && !cmd_valid |=> rsp_valid && !req_valid
            && rsp_bytes[7:0] == 8'h11 && rsp_len == 6'd1);
    // R13
    req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> !rsp_valid && $past(cmd_valid));
    // R9
    req_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_nbytes >= 4'd1 && req_nbytes <= 4'd8);
    // R6
    rsp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_len >= 6'd1 && rsp_len <= 6'd9);
endmodule

bind rmi_cmd_decoder rmi_cmd_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .req_valid(req_valid),
    .req_kind(req_kind), .req_core(req_core), .req_addr(req_addr),
    .req_nbytes(req_nbytes), .req_ack(req_ack), .req_tmo(req_tmo),
    .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_bytes(rsp_bytes)
);

// File: tb/sim_rmi_cmd_decoder.sv
`timescale 1ns/1ps
module sim_rmi_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic [7:0]  cmd_wlen = '0;
    logic [79:0] cmd_bytes = '0;
    logic [15:0] core_ok = 16'hFFFF;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [3:0]  req_core;
    logic        req_all;
    logic [31:0] req_addr;
    logic [3:0]  req_nbytes;
    logic [63:0] req_wdata;
    logic        req_ack = 1'b0;
    logic [63:0] req_rdata = '0;
    logic        req_tmo = 1'b0;
    logic        rsp_valid;
    logic [5:0]  rsp_len;
    logic [71:0] rsp_bytes;

    int checks = 0;
    int fails = 0;

    typedef struct { logic [5:0] len; logic [71:0] bytes; string tag; } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    rmi_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_wlen(cmd_wlen), .cmd_bytes(cmd_bytes), .core_ok(core_ok),
        .req_valid(req_valid), .req_kind(req_kind), .req_core(req_core),
        .req_all(req_all), .req_addr(req_addr), .req_nbytes(req_nbytes),
        .req_wdata(req_wdata), .req_ack(req_ack), .req_rdata(req_rdata),
        .req_tmo(req_tmo), .rsp_valid(rsp_valid), .rsp_len(rsp_len),
        .rsp_bytes(rsp_bytes)
    );

    task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_rsp(input logic [5:0] len, input logic [7:0] st, input logic [63:0] data, input string tag);
        exp_t e;
        e.len = len; e.bytes = {data, st}; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares each response with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t e;
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R13 unexpected response actual=%h/%0d expected=none", rsp_bytes, rsp_len);
            end else begin
                e = q.pop_front();
                if (rsp_len !== e.len || rsp_bytes !== e.bytes) begin
                    fails++;
                    $display("FAIL %s actual=%h/%0d expected=%h/%0d", e.tag, rsp_bytes, rsp_len, e.bytes, e.len);
                end
            end
        end
    end

    function automatic logic [79:0] rd_pl(input logic [7:0] n, input logic [3:0] c, input logic [31:0] a);
        return {24'h0, a, 3'b000, c, 1'b0, 8'h86, n};
    endfunction
    function automatic logic [79:0] id_pl(input logic [7:0] n, input logic [3:0] c, input logic [31:0] f, input logic [7:0] s);
        return {16'h0, s, f, 3'b000, c, 1'b0, 8'h91, n};
    endfunction
    function automatic logic [79:0] ld_pl(input logic [7:0] cb, input logic [31:0] a);
        return {32'h0, a, cb, 8'h81};
    endfunction
    function automatic logic [79:0] wr_pl(input logic [7:0] cb, input logic [63:0] d);
        return {d, cb, 8'h87};
    endfunction

    // Driver: one-cycle command strobe, returns at the falling edge after capture.
    task automatic send(input logic [7:0] code, input logic [7:0] wlen, input logic [79:0] pl);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_wlen = wlen; cmd_bytes = pl;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic ack(input logic [63:0] d);
        req_ack = 1'b1; req_rdata = d;
        @(negedge clk);
        req_ack = 1'b0;
    endtask

    task automatic check_req(input logic [1:0] k, input logic [3:0] c, input logic [31:0] a,
                             input logic [3:0] n, input logic [63:0] w, input string tag);
        chk(req_valid === 1'b1, {tag, " req_valid"}, 80'(req_valid), 80'(1));
        chk(req_kind === k, {tag, " kind"}, 80'(req_kind), 80'(k));
        chk(req_core === c, {tag, " core"}, 80'(req_core), 80'(c));
        chk(req_addr === a, {tag, " addr"}, 80'(req_addr), 80'(a));
        chk(req_nbytes === n, {tag, " nbytes"}, 80'(req_nbytes), 80'(n));
        chk(req_wdata === w, {tag, " wdata"}, 80'(req_wdata), 80'(w));
    endtask

    bit done = 1'b0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_valid === 1'b0, "R1 req_valid in reset", 80'(req_valid), 80'(0));
        chk(rsp_valid === 1'b0, "R1 rsp_valid in reset", 80'(rsp_valid), 80'(0));
        rst_n = 1'b1;
        @(negedge clk);
        // R1: saved result after reset is 00h, zero data
        expect_rsp(6'd3, 8'h00, 64'h0, "R1 read-back after reset");
        send(8'h72, 8'd1, 80'h02);

        // R4 load core 3, then R5 write core 3
        expect_rsp(6'd1, 8'h00, 64'h0, "R4 load core 3");
        send(8'h71, 8'd6, ld_pl(8'h06, 32'hC001_0063));
        chk(req_valid === 1'b0, "R4 load issues no request", 80'(req_valid), 80'(0));
        send(8'h71, 8'd6, wr_pl(8'h06, 64'hFFFF_FFFF_4433_2211));
        check_req(2'd2, 4'd3, 32'hC001_0063, 4'd4, 64'h4433_2211, "R5 write core 3");
        expect_rsp(6'd1, 8'h00, 64'h0, "R5 write done");
        ack(64'h1234);

        // R4 broadcast load, R5 write core 7 with one byte
        expect_rsp(6'd1, 8'h00, 64'h0, "R4 broadcast load");
        send(8'h71, 8'd6, ld_pl(8'h01, 32'h0000_0179));
        send(8'h71, 8'd3, wr_pl(8'h0E, 64'hAAAA_5A));
        check_req(2'd2, 4'd7, 32'h0000_0179, 4'd1, 64'h5A, "R4 R5 broadcast address used");
        expect_rsp(6'd1, 8'h00, 64'h0, "R5 write done");
        ack(64'h0);

        // R2 register read, 3 bytes, core 5
        send(8'h73, 8'd7, rd_pl(8'd3, 4'd5, 32'hC001_003E));
        check_req(2'd0, 4'd5, 32'hC001_003E, 4'd3, 64'h0, "R2 read core 5");
        expect_rsp(6'd4, 8'h00, 64'h33_2211, "R2 read response");
        ack(64'h8877_6655_4433_2211);

        // R6 read-back of 5 bytes
        expect_rsp(6'd6, 8'h00, 64'h55_4433_2211, "R6 read-back 5 bytes");
        send(8'h72, 8'd1, 80'h05);

        // R3 CPUID core 2, selector 1
        send(8'h73, 8'd8, id_pl(8'd8, 4'd2, 32'h8000_0001, 8'h01));
        check_req(2'd1, 4'd2, 32'h8000_0001, 4'd8, 64'h1, "R3 cpuid request");
        expect_rsp(6'd9, 8'h00, 64'h0102_0304_0506_0708, "R3 cpuid response");
        ack(64'h0102_0304_0506_0708);

        // R11 busy, R12 timeout
        send(8'h73, 8'd7, rd_pl(8'd2, 4'd1, 32'h0000_0400));
        expect_rsp(6'd1, 8'h20, 64'h0, "R11 busy read-back");
        send(8'h72, 8'd1, 80'h01);
        chk(req_valid === 1'b1 && req_addr === 32'h0000_0400, "R11 pending request kept",
            80'(req_addr), 80'(32'h0000_0400));
        expect_rsp(6'd1, 8'h20, 64'h0, "R11 busy beats unknown code");
        send(8'h70, 8'd1, 80'h0);
        expect_rsp(6'd1, 8'h11, 64'h0, "R12 timeout response");
        req_tmo = 1'b1;
        @(negedge clk);
        req_tmo = 1'b0;
        chk(req_valid === 1'b0, "R12 request dropped", 80'(req_valid), 80'(0));
        expect_rsp(6'd3, 8'h11, 64'h0, "R12 read-back after timeout");
        send(8'h72, 8'd1, 80'h02);

        // R11 completion in same cycle as a command
        send(8'h73, 8'd7, rd_pl(8'd8, 4'd1, 32'h0000_0010));
        expect_rsp(6'd1, 8'h20, 64'h0, "R11 collision answered busy");
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 8'h72; cmd_wlen = 8'd1; cmd_bytes = 80'h01;
        req_ack = 1'b1; req_rdata = 64'hAABB_CCDD_EEFF_0011;
        @(negedge clk);
        cmd_valid = 1'b0; req_ack = 1'b0;
        expect_rsp(6'd9, 8'h00, 64'hAABB_CCDD_EEFF_0011, "R11 completion saved");
        send(8'h72, 8'd1, 80'h08);

        // R7 unknown formats
        expect_rsp(6'd1, 8'h40, 64'h0, "R7 unknown code");
        send(8'h70, 8'd1, 80'h01);
        expect_rsp(6'd1, 8'h40, 64'h0, "R7 unknown subcommand");
        send(8'h73, 8'd7, {24'h0, 32'h0, 8'h02, 8'h99, 8'h02});

        // R8 read length, R9 unsupported
        expect_rsp(6'd1, 8'h41, 64'h0, "R8 count zero");
        send(8'h73, 8'd7, rd_pl(8'd0, 4'd1, 32'h0));
        expect_rsp(6'd1, 8'h41, 64'h0, "R8 count 33");
        send(8'h72, 8'd1, 80'd33);
        expect_rsp(6'd1, 8'h42, 64'h0, "R8 sum 33");
        send(8'h73, 8'd7, rd_pl(8'd26, 4'd1, 32'h0));
        expect_rsp(6'd1, 8'h45, 64'h0, "R9 count 25 above 8");
        send(8'h73, 8'd7, rd_pl(8'd25, 4'd1, 32'h0));
        expect_rsp(6'd1, 8'h45, 64'h0, "R9 count 32 not total-length error");
        send(8'h72, 8'd1, 80'd32);
        expect_rsp(6'd1, 8'h45, 64'h0, "R9 wrong write length");
        send(8'h73, 8'd6, rd_pl(8'd2, 4'd1, 32'h0));
        expect_rsp(6'd1, 8'h45, 64'h0, "R9 cpuid selector 2");
        send(8'h73, 8'd8, id_pl(8'd8, 4'd1, 32'h0, 8'h02));
        expect_rsp(6'd1, 8'h45, 64'h0, "R9 cpuid count 7");
        send(8'h73, 8'd8, id_pl(8'd7, 4'd1, 32'h0, 8'h00));
        expect_rsp(6'd1, 8'h45, 64'h0, "R9 write length 2");
        send(8'h71, 8'd2, wr_pl(8'h02, 64'h0));
        expect_rsp(6'd1, 8'h45, 64'h0, "R9 write length 11");
        send(8'h71, 8'd11, wr_pl(8'h02, 64'h0));

        // R10 core availability
        core_ok = 16'hFFDF;
        expect_rsp(6'd1, 8'h44, 64'h0, "R10 disabled core");
        send(8'h73, 8'd7, rd_pl(8'd2, 4'd5, 32'h0));
        expect_rsp(6'd1, 8'h41, 64'h0, "R8 read length before core check");
        send(8'h73, 8'd7, rd_pl(8'd0, 4'd5, 32'h0));
        expect_rsp(6'd1, 8'h44, 64'h0, "R10 broadcast load refused");
        send(8'h71, 8'd6, ld_pl(8'h01, 32'hDEAD_BEEF));
        expect_rsp(6'd1, 8'h00, 64'h0, "R10 load enabled core 6");
        send(8'h71, 8'd6, ld_pl(8'h0C, 32'h0000_0400));
        chk(req_valid === 1'b0, "R10 no request on refusal", 80'(req_valid), 80'(0));
        send(8'h71, 8'd3, wr_pl(8'h0E, 64'h77));
        check_req(2'd2, 4'd7, 32'h0000_0179, 4'd1, 64'h77, "R10 refused load stored nothing");
        expect_rsp(6'd1, 8'h00, 64'h0, "R5 write done");
        ack(64'h0);
        send(8'h71, 8'd3, wr_pl(8'h0C, 64'h66));
        check_req(2'd2, 4'd6, 32'h0000_0400, 4'd1, 64'h66, "R4 core 6 address");
        expect_rsp(6'd1, 8'h00, 64'h0, "R5 write done");
        ack(64'h0);
        core_ok = 16'hFFFF;

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R13 all expected responses seen", 80'(q.size()), 80'(0));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule